// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors held in system memory. For each descriptor it collects the buffer segment the descriptor points at. It sends those bytes out as a byte stream and marks the final byte of every frame. It reaches memory through a single word-wide request port, which it uses both for descriptor fetches and for buffer reads. When it has finished with a descriptor, it hands that descriptor back to software. It does this by writing the control word back with the ownership bit cleared.

Each descriptor is 16 bytes long and is made of four little-endian words:

| Word | Byte offset | Contents |
|------|-------------|----------|
| 0 | 0 | Control word |
| 1 | 4 | Option word |
| 2 | 8 | Ignored |
| 3 | 12 | Buffer byte address |

The control word fields are:
- bits [13:0]: segment byte count
- bit 15: end of ring
- bit 28: last segment
- bit 29: first segment
- bit 31: owned by the engine

The option word fields are:
- bit 31: request a completion pulse
- bit 30: request a moved pulse

Software sets up the ring in three steps:
1. It writes the ring base with a strobe.
2. It marks descriptors as owned.
3. It pulses the poll input.

The engine then processes descriptors until it reads one that it does not own. At that point it raises a "no buffer" pulse and goes idle. The current descriptor pointer is kept between walks.

The output stream follows a valid/ready handshake. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the engine holds `tx_valid`, `tx_data` and `tx_last` steady. The memory port follows a similar rule:
- The engine holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` until it sees `mem_gnt`.
- A write completes on its grant.
- A read returns its word on `mem_rvalid` in a later cycle.
- Only one request is ever in flight.

Top module: `txr_dma_engine`

## Requirements
- R1: A poll pulse while `cfg_dma_en` is low is ignored: no memory request and no stream byte follow it.
- R2: A walk first reads the control word at the current descriptor pointer. The option word is read at pointer+4 and the buffer address at pointer+12. Buffer bytes are little-endian: the byte at address a is word bits [8*(a mod 4)+7 : 8*(a mod 4)]. Buffers may start at any byte address.
- R3: A control word with bit 31 clear ends the walk with a one-cycle `irq_nobuf` pulse. It produces no stream byte and no memory write.
- R4: When the engine has finished with a descriptor, it writes that descriptor's control word back to the descriptor's address with bit 31 cleared. All other bits are unchanged.
- R5: After the write-back, the pointer advances by 16 bytes. If control bit 15 was set, it returns to the ring base instead.
- R6: Segments are chained into frames. Bit 29 starts a new frame. The final byte of a descriptor with bit 28 set carries `tx_last`, and no other byte does.
- R7: Write-back of a last-segment descriptor whose option bit 31 is set gives one `irq_done` pulse. If option bit 31 is clear, no pulse is given.
- R8: Write-back of any descriptor whose option bit 30 is set gives one `irq_moved` pulse.
- R9: A frame is limited to 1522 bytes, or 9220 bytes when `cfg_jumbo` is high. The byte that reaches the limit carries `tx_last`, and the rest of that frame's data is discarded.
- R10: A ring-base write also moves the pointer to the base. Otherwise the pointer is kept between walks, and a new walk resumes where the last one stopped.
- R11: Poll pulses that arrive while a walk is running are merged into one. That single pending walk starts once the engine is idle again.
- R12: The engine holds stream and memory request outputs stable while the other side stalls. It never presents a stream byte and a memory request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dma_en | input | 1 | Transmit DMA enable |
| cfg_jumbo | input | 1 | Selects the larger frame limit |
| base_wr | input | 1 | Ring-base write strobe |
| base_val | input | 32 | Ring base byte address |
| poll_req | input | 1 | Poll-demand pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream sink ready |
| irq_done | output | 1 | Completion pulse |
| irq_moved | output | 1 | Moved-to-FIFO pulse |
| irq_nobuf | output | 1 | No owned descriptor pulse |

## Verification
A corrupted descriptor pointer shows at the ports within a few cycles. The next control-word read goes to the wrong address, and the write-back lands on the wrong word in memory. A stale frame counter appears at the end of a frame: `tx_last` arrives early or late against the limit, or truncation begins too soon. A dropped or duplicated pending poll changes the number of `irq_nobuf` pulses once the engine next goes idle.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_BYTES   = 16;
  localparam int CW_OWN       = 31;
  localparam int CW_FIRST     = 29;
  localparam int CW_LAST      = 28;
  localparam int CW_RING_END  = 15;
  localparam int OW_DONE_REQ  = 31;
  localparam int OW_MOVED_REQ = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTRL,
    ST_RD_OPT,
    ST_RD_BUF,
    ST_FETCH,
    ST_EMIT,
    ST_WBACK
  } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr    <= '0;
    end else if (base_wr) begin
      base_q <= base_val;
      ptr    <= base_val;
    end else if (adv) begin
      ptr <= wrap ? base_q : ptr + ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/txr_frame_len.sv
module txr_frame_len #(
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 9220,
  parameter int CNT_W     = $clog2(JUMBO_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jumbo,
  input  logic clr,
  input  logic inc,
  output logic full,
  output logic at_edge
);
  localparam logic [CNT_W-1:0] LIM_STD   = CNT_W'(STD_MAX);
  localparam logic [CNT_W-1:0] LIM_JUMBO = CNT_W'(JUMBO_MAX);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit   = jumbo ? LIM_JUMBO : LIM_STD;
  assign full    = (cnt >= limit);
  assign at_edge = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !full)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic [7:0]        byte_o
);
  logic [WORD_W-1:0] hold;
  logic [7:0]        lanes [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= '0;
    else if (load) hold <= word;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = hold[g*8 +: 8];
  end

  assign byte_o = lanes[sel];
endmodule

// File: rtl/txr_dma_engine.sv
module txr_dma_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 9220
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dma_en,
  input  logic              cfg_jumbo,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              poll_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              irq_done,
  output logic              irq_moved,
  output logic              irq_nobuf
);
  localparam int CNT_W = $clog2(JUMBO_MAX + 1);

  txr_state_e        st;
  logic              rd_wait, pend;
  logic [31:0]       cw;
  logic              ow_done, ow_moved;
  logic [ADDR_W-1:0] baddr;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] ptr;
  logic              rd_state, rsp, beat, start;
  logic              fr_clr, fr_full, fr_edge, lane_load, ptr_adv, wb_done;
  logic              seg_end;

  assign rd_state  = (st == ST_RD_CTRL) || (st == ST_RD_OPT) ||
                     (st == ST_RD_BUF)  || (st == ST_FETCH);
  assign rsp       = rd_wait && mem_rvalid;
  assign mem_req   = (rd_state && !rd_wait) || (st == ST_WBACK);
  assign mem_we    = (st == ST_WBACK);
  assign mem_wdata = cw & ~(32'h1 << CW_OWN);
  assign wb_done   = (st == ST_WBACK) && mem_gnt;

  always_comb begin
    case (st)
      ST_RD_OPT: mem_addr = ptr + ADDR_W'(4);
      ST_RD_BUF: mem_addr = ptr + ADDR_W'(12);
      ST_FETCH:  mem_addr = {baddr[ADDR_W-1:2], 2'b00};
      default:   mem_addr = ptr;
    endcase
  end

  assign tx_valid  = (st == ST_EMIT);
  assign seg_end   = (rem == LEN_W'(1));
  assign tx_last   = tx_valid && ((cw[CW_LAST] && seg_end) || fr_edge);
  assign beat      = tx_valid && tx_ready;
  assign start     = (st == ST_IDLE) && cfg_dma_en && (poll_req || pend);
  assign fr_clr    = ((st == ST_RD_CTRL) && rsp && mem_rdata[CW_OWN] && mem_rdata[CW_FIRST]) ||
                     (wb_done && cw[CW_LAST]);
  assign lane_load = (st == ST_FETCH) && rsp;
  assign ptr_adv   = wb_done;

  txr_ring_ptr #(.ADDR_W(ADDR_W), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_val(base_val),
    .adv(ptr_adv), .wrap(cw[CW_RING_END]), .ptr(ptr)
  );

  txr_frame_len #(.STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .jumbo(cfg_jumbo), .clr(fr_clr), .inc(beat),
    .full(fr_full), .at_edge(fr_edge)
  );

  txr_byte_lane #(.WORD_W(32)) u_lane (
    .clk(clk), .rst_n(rst_n), .load(lane_load), .word(mem_rdata),
    .sel(baddr[1:0]), .byte_o(tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rd_wait   <= 1'b0;
      pend      <= 1'b0;
      cw        <= '0;
      ow_done   <= 1'b0;
      ow_moved  <= 1'b0;
      baddr     <= '0;
      rem       <= '0;
      irq_done  <= 1'b0;
      irq_moved <= 1'b0;
      irq_nobuf <= 1'b0;
    end else begin
      irq_done  <= 1'b0;
      irq_moved <= 1'b0;
      irq_nobuf <= 1'b0;

      if (st != ST_IDLE && poll_req && cfg_dma_en) pend <= 1'b1;
      else if (start)                               pend <= 1'b0;

      if (rd_state && !rd_wait && mem_gnt) rd_wait <= 1'b1;
      else if (rsp)                        rd_wait <= 1'b0;

      case (st)
        ST_IDLE: if (start) st <= ST_RD_CTRL;
        ST_RD_CTRL: if (rsp) begin
          cw <= mem_rdata;
          if (!mem_rdata[CW_OWN]) begin
            irq_nobuf <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            st <= ST_RD_OPT;
          end
        end
        ST_RD_OPT: if (rsp) begin
          ow_done  <= mem_rdata[OW_DONE_REQ];
          ow_moved <= mem_rdata[OW_MOVED_REQ];
          st       <= ST_RD_BUF;
        end
        ST_RD_BUF: if (rsp) begin
          baddr <= mem_rdata[ADDR_W-1:0];
          rem   <= cw[LEN_W-1:0];
          if (cw[LEN_W-1:0] == '0 || fr_full) st <= ST_WBACK;
          else                                 st <= ST_FETCH;
        end
        ST_FETCH: if (rsp) st <= ST_EMIT;
        ST_EMIT: if (beat) begin
          baddr <= baddr + ADDR_W'(1);
          rem   <= rem - LEN_W'(1);
          if (seg_end || fr_edge)       st <= ST_WBACK;
          else if (baddr[1:0] == 2'b11) st <= ST_FETCH;
        end
        ST_WBACK: if (mem_gnt) begin
          irq_moved <= ow_moved;
          irq_done  <= ow_done && cw[CW_LAST];
          st        <= ST_RD_CTRL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_dma_checker.sv
module txr_dma_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic [7:0]        tx_data,
  input logic              irq_nobuf,
  input logic              irq_done
);
  a_r12_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));

  a_r4_wb_released: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);

  a_r3_pulse_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_nobuf, irq_done}));
endmodule

bind txr_dma_engine txr_dma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_last(tx_last), .tx_data(tx_data), .irq_nobuf(irq_nobuf), .irq_done(irq_done)
);

// File: tb/tb_txr_dma_engine.sv
module tb_txr_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dma_en = 1'b0, cfg_jumbo = 1'b0, base_wr = 1'b0, poll_req = 1'b0;
  logic [31:0] base_val = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_last, tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        irq_done, irq_moved, irq_nobuf;

  txr_dma_engine dut (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:8191];
  logic [7:0]  cap [0:16383];
  logic        capl [0:16383];
  int n_cap, n_done, n_moved, n_nobuf, n_wr, n_rd;
  logic [31:0] first_rd, last_rd;
  int tests = 0, fails = 0;
  bit stall_mode = 0, slow_ready = 0;
  bit rd_pend = 0, gtog = 0;
  logic [31:0] rd_addr;
  int rtog = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + (a >> 8)) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory and sink model, driven away from the active edge
  initial begin
    for (int i = 0; i < 8192; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[rd_addr[14:2]];
        rd_pend    = 0;
      end
      mem_gnt = 1'b0;
      if (mem_req) begin
        gtog = ~gtog;
        if (gtog || !stall_mode) begin
          mem_gnt = 1'b1;
          if (mem_we) begin
            mem[mem_addr[14:2]] = mem_wdata;
            n_wr++;
          end else begin
            rd_pend = 1;
            rd_addr = mem_addr;
            if (n_rd == 0) first_rd = mem_addr;
            last_rd = mem_addr;
            n_rd++;
          end
        end
      end
      rtog++;
      tx_ready = slow_ready ? (rtog % 3 == 0) : 1'b1;
      if (tx_valid && tx_ready) begin
        cap[n_cap]  = tx_data;
        capl[n_cap] = tx_last;
        n_cap++;
      end
      if (irq_done)  n_done++;
      if (irq_moved) n_moved++;
      if (irq_nobuf) n_nobuf++;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic clear_counts();
    n_cap = 0; n_done = 0; n_moved = 0; n_nobuf = 0; n_wr = 0; n_rd = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, input logic [31:0] o,
                          input logic [31:0] b);
    mem[a >> 2] = c; mem[(a >> 2) + 1] = o; mem[(a >> 2) + 2] = 32'h0; mem[(a >> 2) + 3] = b;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); base_val = b; base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic poll();
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
  endtask

  task automatic wait_nobuf(input int target);
    int guard = 0;
    while (n_nobuf < target && guard < 40000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(n_nobuf >= target, "walk end", n_nobuf, target);
  endtask

  // checks a captured frame against consecutive segments
  task automatic check_bytes(input string req, input int a0, input int l0, input int a1,
                             input int total);
    int bad = 0, lastbad = 0;
    for (int i = 0; i < total; i++) begin
      logic [7:0] e;
      e = (i < l0) ? pat(a0 + i) : pat(a1 + i - l0);
      if (cap[i] !== e) bad++;
      if (capl[i] !== (i == total - 1)) lastbad++;
    end
    chk(n_cap == total, req, n_cap, total);
    chk(bad == 0, req, bad, 0);
    chk(lastbad == 0, {req, " last marker"}, lastbad, 0);
  endtask

  task automatic t_reset();
    chk(!tx_valid && !mem_req && !irq_done && !irq_moved && !irq_nobuf, "reset",
        {tx_valid, mem_req, irq_nobuf}, 0);
  endtask

  task automatic t_disabled();  // R1
    clear_counts();
    cfg_dma_en = 1'b0;
    set_base(32'h100);
    poll();
    repeat (20) @(negedge clk);
    chk(n_rd == 0 && n_cap == 0, "R1", n_rd, 0);
  endtask

  task automatic t_single();  // R2 R4 R6 R7 R8
    clear_counts();
    cfg_dma_en = 1'b1;
    put_desc(32'h100, 32'hB000_0006, 32'h8000_0000, 32'h403);
    mem[32'h110 >> 2] = 32'h0;
    poll();
    wait_nobuf(1);
    chk(first_rd == 32'h100, "R2 first read", first_rd, 32'h100);
    check_bytes("R2 R6 single", 32'h403, 6, 0, 6);
    chk(n_done == 1, "R7", n_done, 1);
    chk(n_moved == 0, "R8 none", n_moved, 0);
    chk(mem[32'h100 >> 2] == 32'h3000_0006, "R4", mem[32'h100 >> 2], 32'h3000_0006);
  endtask

  task automatic t_resume();  // R10 R7
    clear_counts();
    put_desc(32'h110, 32'hB000_0002, 32'h0, 32'h500);
    mem[32'h120 >> 2] = 32'h0;
    poll();
    wait_nobuf(1);
    check_bytes("R10 resume", 32'h500, 2, 0, 2);
    chk(n_done == 0, "R7 no request", n_done, 0);
  endtask

  task automatic t_chain_wrap();  // R5 R6 R8 R12
    clear_counts();
    stall_mode = 1; slow_ready = 1;
    set_base(32'h200);
    put_desc(32'h200, 32'hA000_0005, 32'h0, 32'h600);
    put_desc(32'h210, 32'h9000_8003, 32'h4000_0000, 32'h701);
    poll();
    wait_nobuf(1);
    check_bytes("R6 R12 chain", 32'h600, 5, 32'h701, 8);
    chk(n_moved == 1, "R8", n_moved, 1);
    chk(last_rd == 32'h200, "R5 wrap", last_rd, 32'h200);
    chk(mem[32'h210 >> 2] == 32'h1000_8003, "R4 chain", mem[32'h210 >> 2], 32'h1000_8003);
    clear_counts();
    put_desc(32'h200, 32'hB000_0001, 32'h0, 32'h800);
    poll();
    wait_nobuf(1);
    check_bytes("R5 after wrap", 32'h800, 1, 0, 1);
    stall_mode = 0; slow_ready = 0;
  endtask

  task automatic t_not_owned();  // R3
    clear_counts();
    set_base(32'h300);
    put_desc(32'h300, 32'h3000_0004, 32'h8000_0000, 32'h800);
    poll();
    wait_nobuf(1);
    chk(n_nobuf == 1 && n_cap == 0 && n_wr == 0 && n_done == 0, "R3", n_cap + n_wr, 0);
  endtask

  task automatic t_limit_std();  // R9
    clear_counts();
    cfg_jumbo = 1'b0;
    set_base(32'h900);
    put_desc(32'h900, 32'hA000_0000 | 32'd1000, 32'h0, 32'h1000);
    put_desc(32'h910, 32'h9000_0000 | 32'd1000, 32'h8000_0000, 32'h1000);
    mem[32'h920 >> 2] = 32'h0;
    poll();
    wait_nobuf(1);
    check_bytes("R9 std", 32'h1000, 1000, 32'h1000, 1522);
    chk(n_done == 1, "R9 R7 done", n_done, 1);
  endtask

  task automatic t_limit_jumbo();  // R9
    clear_counts();
    cfg_jumbo = 1'b1;
    set_base(32'h980);
    put_desc(32'h980, 32'hB000_0000 | 32'd9300, 32'h0, 32'h1000);
    mem[32'h990 >> 2] = 32'h0;
    poll();
    wait_nobuf(1);
    check_bytes("R9 jumbo", 32'h1000, 9300, 0, 9220);
    cfg_jumbo = 1'b0;
  endtask

  task automatic t_pending();  // R11
    clear_counts();
    set_base(32'hA00);
    put_desc(32'hA00, 32'hB000_0004, 32'h0, 32'h800);
    mem[32'hA10 >> 2] = 32'h0;
    poll();
    repeat (2) @(negedge clk);
    poll();
    poll();
    wait_nobuf(2);
    repeat (60) @(negedge clk);
    chk(n_nobuf == 2, "R11", n_nobuf, 2);
    chk(n_cap == 4, "R11 data", n_cap, 4);
  endtask

  initial begin
    clear_counts();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_disabled();
    t_single();
    t_resume();
    t_chain_wrap();
    t_not_owned();
    t_limit_std();
    t_limit_jumbo();
    t_pending();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule